// File: doc/BRIEF.md
# Mode-Partitioned Direct-Mapped Read Cache

This block sits between a processor and main memory and keeps recently read words on chip. Its storage is two equal direct-mapped partitions: user mode uses one and supervisor mode uses the other. The mode bit that comes with each request picks the partition for both lookup and fill. The result is that kernel and application code can never evict each other's lines. Lookups are tagged with the physical address. Each line holds one 32-bit word.

The processor side takes one request at a time. The processor holds a request until `cpu_ready_o` pulses. A read hit completes one cycle after it is accepted and does not touch memory. A read miss goes to memory, waits for the reply, and fills the line in the same cycle it returns the data. Writes always go through to memory, and they only update a line that already hits. Addresses in the I/O region (top address bit set) skip the cache entirely.

Top module: `smc_top`

## Requirements
- R1: After reset no line is valid in either partition: the first read of any address issues a memory request. While in reset, `cpu_ready_o` and `ram_req_o` are low.
- R2: A read miss issues a memory read to the requested address. It raises `cpu_ready_o` in the cycle `ram_ack_i` arrives, returns `ram_rdata_i`, and fills the line in the current mode's partition.
- R3: A read hit raises `cpu_ready_o` one cycle after the request is accepted, returns the cached word, and issues no memory request.
- R4: The line index is addr[12:2] and the tag is addr[31:13]. Two addresses with the same index and different tags evict each other within one partition. Different indices do not interfere.
- R5: `cpu_super_i`=1 selects the supervisor partition and 0 selects the user partition. A line filled in one partition is not a hit in the other, and an eviction in one leaves the other unchanged.
- R6: An address with bit 31 set is always sent to memory, never hits and never fills.
- R7: Every write is sent to memory with its address and data. `cpu_ready_o` is raised in the cycle of `ram_ack_i`.
- R8: A write that hits updates the cached word only in the current mode's partition. A copy of the same address in the other partition keeps its old value.
- R9: A write that misses does not allocate: a following read of that address still goes to memory.
- R10: A memory request holds its address, direction and data stable until `ram_ack_i`.
- R11: `cpu_ready_o` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_req_i | input | 1 | Request valid, held until `cpu_ready_o` |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_super_i | input | 1 | 1 = supervisor mode, 0 = user mode |
| cpu_addr_i | input | 32 | Physical byte address (word aligned) |
| cpu_wdata_i | input | 32 | Write data |
| cpu_ready_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | 32 | Read data, valid with `cpu_ready_o` |
| ram_req_o | output | 1 | Memory request, held until `ram_ack_i` |
| ram_we_o | output | 1 | Memory write direction |
| ram_addr_o | output | 32 | Memory address |
| ram_wdata_o | output | 32 | Memory write data |
| ram_ack_i | input | 1 | One-cycle memory completion |
| ram_rdata_i | input | 32 | Memory read data, valid with `ram_ack_i` |

## Verification
The assertions check on every cycle the following properties: the completion pulse lasts one cycle, memory requests stay stable until acknowledged, a fill never happens without a memory reply, and at most one partition is written at a time. They also check that writes and I/O accesses only complete on a memory reply. Only the bench scenarios can show the data-dependent behaviour. This includes hit versus miss latency, conflict eviction on a shared index, and the independence of the two partitions under both reads and writes. It also includes the absence of allocation on a write miss, and the stale-copy effect that proves a hit never reaches memory.

// File: rtl/smc_pkg.sv
package smc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_RAM
  } smc_state_e;

  localparam int unsigned N_PARTS = 2;  // index 0 user, 1 supervisor
endpackage

// File: rtl/smc_bank.sv
module smc_bank #(
  parameter int unsigned LINES  = 2048,
  parameter int unsigned TAG_W  = 19,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_mem  [LINES];
  logic [DATA_W-1:0] data_mem [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_mem[wr_idx_i]  <= wr_tag_i;
      data_mem[wr_idx_i] <= wr_data_i;
    end
  end

  // registered read port; outputs hold until the next rd_en_i
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_valid_o <= 1'b0;
    else if (rd_en_i) rd_valid_o <= valid_q[rd_idx_i];
  end

  always_ff @(posedge clk_i) begin
    if (rd_en_i) begin
      rd_tag_o  <= tag_mem[rd_idx_i];
      rd_data_o <= data_mem[rd_idx_i];
    end
  end
endmodule

// File: rtl/smc_ctrl.sv
module smc_ctrl
  import smc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic we_i,
  input  logic io_i,
  input  logic hit_i,
  input  logic ram_ack_i,
  output logic accept_o,
  output logic from_cache_o,
  output logic ram_req_o,
  output logic ready_o,
  output logic fill_o
);
  smc_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d      = state_q;
    accept_o     = 1'b0;
    from_cache_o = 1'b0;
    ram_req_o    = 1'b0;
    ready_o      = 1'b0;
    fill_o       = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          accept_o = 1'b1;
          state_d  = ST_LOOK;
        end
      end
      ST_LOOK: begin
        if (!we_i && !io_i && hit_i) begin
          ready_o      = 1'b1;
          from_cache_o = 1'b1;
          state_d      = ST_IDLE;
        end else begin
          state_d = ST_RAM;
        end
      end
      ST_RAM: begin
        ram_req_o = 1'b1;
        if (ram_ack_i) begin
          ready_o = 1'b1;
          // read miss allocates; write updates only on hit; I/O never
          fill_o  = !io_i && (!we_i || hit_i);
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  p_ready_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  p_hit_no_ram_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !ram_ack_i) |-> !ram_req_o);
endmodule

// File: rtl/smc_top.sv
module smc_top
  import smc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned PART_LINES = 2048
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic              cpu_super_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              ram_req_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic              ram_ack_i,
  input  logic [DATA_W-1:0] ram_rdata_i
);
  localparam int unsigned IDX_W = $clog2(PART_LINES);
  localparam int unsigned OFF_W = $clog2(DATA_W / 8);
  localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W;

  logic              accept, from_cache, fill, hit, io_q;
  logic              we_q, super_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [IDX_W-1:0]  idx_q;
  logic [TAG_W-1:0]  tag_q;

  logic              b_valid [N_PARTS];
  logic [TAG_W-1:0]  b_tag   [N_PARTS];
  logic [DATA_W-1:0] b_data  [N_PARTS];
  logic [N_PARTS-1:0] b_we;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      super_q <= 1'b0;
    end else if (accept) begin
      addr_q  <= cpu_addr_i;
      wdata_q <= cpu_wdata_i;
      we_q    <= cpu_we_i;
      super_q <= cpu_super_i;
    end
  end

  assign idx_q = addr_q[OFF_W +: IDX_W];
  assign tag_q = addr_q[ADDR_W-1 -: TAG_W];
  assign io_q  = addr_q[ADDR_W-1];
  assign hit   = b_valid[super_q] && (b_tag[super_q] == tag_q);

  for (genvar g = 0; g < N_PARTS; g++) begin : g_part
    assign b_we[g] = fill && (super_q == 1'(g));
    smc_bank #(
      .LINES (PART_LINES),
      .TAG_W (TAG_W),
      .DATA_W(DATA_W)
    ) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rd_en_i   (accept),
      .rd_idx_i  (cpu_addr_i[OFF_W +: IDX_W]),
      .rd_valid_o(b_valid[g]),
      .rd_tag_o  (b_tag[g]),
      .rd_data_o (b_data[g]),
      .wr_en_i   (b_we[g]),
      .wr_idx_i  (idx_q),
      .wr_tag_i  (tag_q),
      .wr_data_i (we_q ? wdata_q : ram_rdata_i)
    );
  end

  smc_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (cpu_req_i),
    .we_i        (we_q),
    .io_i        (io_q),
    .hit_i       (hit),
    .ram_ack_i   (ram_ack_i),
    .accept_o    (accept),
    .from_cache_o(from_cache),
    .ram_req_o   (ram_req_o),
    .ready_o     (cpu_ready_o),
    .fill_o      (fill)
  );

  assign cpu_rdata_o = from_cache ? b_data[super_q] : ram_rdata_i;
  assign ram_we_o    = we_q;
  assign ram_addr_o  = addr_q;
  assign ram_wdata_o = wdata_q;

  p_ram_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_req_o && !ram_ack_i) |=> (ram_req_o && $stable(ram_addr_o)
                                   && $stable(ram_we_o) && $stable(ram_wdata_o)));

  p_fill_on_ack_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|b_we) |-> ram_ack_i);

  p_one_part_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(b_we));

  p_write_through_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_ready_o && we_q) |-> ram_ack_i);

  p_io_bypass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_ready_o && io_q) |-> (ram_ack_i && !(|b_we)));
endmodule

// File: tb/smc_top_tb.sv
`timescale 1ns/1ps
module smc_top_tb;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, sup = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic        cpu_ready_o, ram_req_o, ram_we_o;
  logic [31:0] cpu_rdata_o, ram_addr_o, ram_wdata_o;
  logic        ram_ack = 1'b0;
  logic [31:0] ram_rdata = '0;

  int total = 0, bad = 0;
  int n_ram = 0, cnt_dn = 0;
  logic [31:0] start_addr, end_addr;
  logic        start_we;
  logic [31:0] mem [logic [31:0]];

  always #2 clk = ~clk;

  smc_top u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(req), .cpu_we_i(we), .cpu_super_i(sup),
    .cpu_addr_i(addr), .cpu_wdata_i(wdata),
    .cpu_ready_o(cpu_ready_o), .cpu_rdata_o(cpu_rdata_o),
    .ram_req_o(ram_req_o), .ram_we_o(ram_we_o),
    .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o),
    .ram_ack_i(ram_ack), .ram_rdata_i(ram_rdata)
  );

  function automatic logic [31:0] pat(logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9bdf;
  endfunction

  function automatic logic [31:0] mem_rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : pat(a);
  endfunction

  // memory model: fixed latency, one-cycle ack
  always @(posedge clk) begin
    ram_ack <= 1'b0;
    if (cnt_dn != 0) begin
      cnt_dn <= cnt_dn - 1;
      if (cnt_dn == 1) begin
        ram_ack  <= 1'b1;
        end_addr <= ram_addr_o;
        if (ram_we_o) mem[ram_addr_o] = ram_wdata_o;
        else          ram_rdata <= mem_rd(ram_addr_o);
      end
    end else if (ram_req_o && !ram_ack) begin
      cnt_dn     <= LAT;
      n_ram      <= n_ram + 1;
      start_addr <= ram_addr_o;
      start_we   <= ram_we_o;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic s, input logic [31:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output int cyc, output int nr);
    int r0;
    r0 = n_ram;
    @(negedge clk);
    req = 1'b1; we = w; sup = s; addr = a; wdata = d;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_ready_o && cyc < 200);
    rd = cpu_rdata_o;
    req = 1'b0;
    nr = n_ram - r0;
    if (nr > 0) begin
      chk(start_addr == a && end_addr == a && start_we == w, "R10 ram request", start_addr, a);
    end
    @(negedge clk);
    chk(!cpu_ready_o, "R11 ready pulse", 32'(cpu_ready_o), 32'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!cpu_ready_o && !ram_req_o, "R1 reset outputs", {30'd0, cpu_ready_o, ram_req_o}, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_miss_hit();
    logic [31:0] rd; int cyc, nr;
    acc(0, 0, 32'h100, 0, rd, cyc, nr);
    chk(nr == 1, "R1 first read misses", nr, 1);
    chk(rd == pat(32'h100), "R2 miss data", rd, pat(32'h100));
    acc(0, 0, 32'h100, 0, rd, cyc, nr);
    chk(cyc == 1, "R3 hit latency", cyc, 1);
    chk(nr == 0, "R3 hit no ram", nr, 0);
    mem[32'h100] = 32'hDEAD_0001;
    acc(0, 0, 32'h100, 0, rd, cyc, nr);
    chk(rd == pat(32'h100), "R3 hit data from cache", rd, pat(32'h100));
  endtask

  task automatic t_conflict();
    logic [31:0] rd; int cyc, nr;
    acc(0, 0, 32'h104, 0, rd, cyc, nr);  // neighbour index
    acc(0, 0, 32'h100, 0, rd, cyc, nr);
    chk(nr == 0, "R4 other index keeps line", nr, 0);
    acc(0, 0, 32'h2100, 0, rd, cyc, nr);  // same index, new tag
    chk(nr == 1 && rd == pat(32'h2100), "R4 conflict miss", rd, pat(32'h2100));
    acc(0, 0, 32'h100, 0, rd, cyc, nr);
    chk(nr == 1, "R4 evicted line misses", nr, 1);
    chk(rd == 32'hDEAD_0001, "R4 refetched data", rd, 32'hDEAD_0001);
  endtask

  task automatic t_partition();
    logic [31:0] rd; int cyc, nr;
    logic [31:0] p;
    p = 32'h400;
    acc(0, 0, p, 0, rd, cyc, nr);
    acc(0, 1, p, 0, rd, cyc, nr);
    chk(nr == 1, "R5 other partition misses", nr, 1);
    acc(1, 1, p, 32'hCAFE_5555, rd, cyc, nr);
    chk(nr == 1 && mem_rd(p) == 32'hCAFE_5555, "R7 write reaches ram", mem_rd(p), 32'hCAFE_5555);
    acc(0, 0, p, 0, rd, cyc, nr);
    chk(nr == 0 && rd == pat(p), "R8 user copy untouched", rd, pat(p));
    acc(0, 1, p, 0, rd, cyc, nr);
    chk(nr == 0 && rd == 32'hCAFE_5555, "R8 supervisor copy updated", rd, 32'hCAFE_5555);
    acc(0, 0, p + 32'h2000, 0, rd, cyc, nr);  // evict user line only
    acc(0, 1, p, 0, rd, cyc, nr);
    chk(nr == 0, "R5 supervisor survives user eviction", nr, 0);
  endtask

  task automatic t_io();
    logic [31:0] rd; int cyc, nr;
    logic [31:0] a;
    a = 32'h8000_0040;
    acc(0, 0, a, 0, rd, cyc, nr);
    chk(nr == 1 && rd == pat(a), "R6 io read", rd, pat(a));
    mem[a] = 32'h0BAD_F00D;
    acc(0, 0, a, 0, rd, cyc, nr);
    chk(nr == 1 && rd == 32'h0BAD_F00D, "R6 io not cached", rd, 32'h0BAD_F00D);
    acc(0, 1, a, 0, rd, cyc, nr);
    chk(nr == 1, "R6 io supervisor bypass", nr, 1);
  endtask

  task automatic t_write_miss();
    logic [31:0] rd; int cyc, nr;
    acc(1, 0, 32'h800, 32'h1234_5678, rd, cyc, nr);
    chk(nr == 1 && cyc > 1, "R7 write waits for ram", cyc, 32'(LAT + 2));
    acc(0, 0, 32'h800, 0, rd, cyc, nr);
    chk(nr == 1, "R9 no allocate on write miss", nr, 1);
    chk(rd == 32'h1234_5678, "R9 read after write", rd, 32'h1234_5678);
  endtask

  task automatic t_rereset();
    logic [31:0] rd; int cyc, nr;
    do_reset();
    acc(0, 1, 32'h400, 0, rd, cyc, nr);
    chk(nr == 1, "R1 reset clears valid", nr, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    t_miss_hit();
    t_conflict();
    t_partition();
    t_io();
    t_write_miss();
    t_rereset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule